// File: doc/BRIEF.md
# Parallel EEPROM Page Writer

This block is a bus master that copies a run of bytes from a ready/valid stream into a byte-wide parallel EEPROM. A transfer is started with a first address, a byte count and a choice of completion method. The writer drives the memory address and data buses and the active-low chip-select, read-strobe and write-strobe lines. Each byte goes in as a write-strobe-controlled load. Bytes are grouped into page bursts that never leave one 256-byte page. After each burst the writer lets the device program itself before it starts the next burst.

The programming wait is either a fixed count of clocks or a sequence of status reads. A status read fetches the last byte written and compares it with the value sent. A page burst also ends early when the input stream stalls for too long, because the device starts programming on its own when the next load is late. The setup, strobe-low and recovery lengths, the stall limit and the programming time are all clock counts set by parameters.

Top module: `eep_page_writer`

## Requirements
- R1: After reset the writer is idle. The chip-select, read-strobe and write-strobe outputs are high, the data bus is not driven, `s_ready` is low, and `busy` and `done` are low.
- R2: Every byte load holds chip-select low and the read strobe high. The write strobe stays low for exactly PULSE_CYC clocks, and the address and data do not change while it is low.
- R3: The data bus is driven only while the read strobe is high.
- R4: The byte accepted n-th from the stream (counting from 0) is written to `start_addr + n`.
- R5: All loads of one burst share address bits 16:8. A transfer that crosses a 256-byte boundary is therefore written as separate bursts, each followed by its own programming wait.
- R6: Within a burst, consecutive write-strobe falling edges are at most GAP_LIMIT + SETUP_CYC clocks apart. If the stream delivers no byte within GAP_LIMIT clocks of the last falling edge, the burst is closed and programming begins.
- R7: With polling off, no write-strobe falling edge follows the final rising edge of a burst by fewer than PROG_CYC clocks.
- R8: With polling on, the writer repeatedly reads the last written address, with chip-select low, the write strobe high and the read strobe low. A read that returns the byte just written ends the wait early.
- R9: With polling on, if no matching read has been seen after PROG_CYC clocks, the transfer ends with `done` and `err` high.
- R10: If `start_addr + byte_count` exceeds 131072, the transfer ends at once with `done` and `err` high and no strobe activity. A transfer that ends exactly at address 0x1FFFF is legal.
- R11: `done` is a single-clock pulse. A byte count of zero yields `done` with `err` low and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a transfer when idle |
| start_addr | input | 17 | First EEPROM byte address |
| byte_count | input | 18 | Number of bytes to write (0 to 131072) |
| poll_en | input | 1 | 1 = status polling, 0 = fixed programming wait |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Writer accepts a stream byte |
| mem_addr | output | 17 | EEPROM address bus |
| mem_dout | output | 8 | Data driven toward the EEPROM |
| mem_drv | output | 1 | Enable for the data bus driver |
| mem_din | input | 8 | Data read back from the EEPROM |
| ce_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| err | output | 1 | Range overflow or poll timeout for the last transfer |

## Verification
Each kind of internal fault shows at the pins soon after it occurs.
- A wrong address counter sends a byte to the wrong location or moves the page bits inside a burst. This is visible at the very next write-strobe edge.
- A wrong phase counter changes the strobe-low width on the first load.
- A wrong stall or programming counter shows as a burst that splits, or fails to split, as expected. It can also show as a new load arriving before the programming time has passed.
- A faulty poll comparison shows up within one programming time, either as `done` arriving too early or too late, or as a spurious `err`.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam int EEPW_ADDR_W = 17;
    localparam int EEPW_DATA_W = 8;
    localparam int EEPW_PAGE_W = 8;
    localparam int EEPW_CNT_W  = EEPW_ADDR_W + 1;
    localparam int EEPW_PGN_W  = EEPW_ADDR_W - EEPW_PAGE_W;

    typedef logic [EEPW_ADDR_W-1:0] addr_t;
    typedef logic [EEPW_DATA_W-1:0] data_t;
    typedef logic [EEPW_CNT_W-1:0]  cnt_t;
    typedef logic [EEPW_PGN_W-1:0]  pgn_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } beat_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_SETUP,
        S_PULSE,
        S_RECOV,
        S_PROG,
        S_PHOLD,
        S_PREAD,
        S_DONE
    } wst_t;

    function automatic pgn_t page_of(addr_t a);
        return a[EEPW_ADDR_W-1:EEPW_PAGE_W];
    endfunction

    function automatic logic page_last(addr_t a);
        return &a[EEPW_PAGE_W-1:0];
    endfunction

endpackage

// File: rtl/eepw_timer.sv
module eepw_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // saturating up-counter, restarted by clr
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/eepw_span_chk.sv
module eepw_span_chk
    import eepw_pkg::*;
(
    input  addr_t start_addr,
    input  cnt_t  byte_count,
    output logic  ovf,
    output logic  zero
);
    typedef logic [EEPW_CNT_W:0] sum_t;
    localparam sum_t SPACE = sum_t'(1) << EEPW_ADDR_W;

    sum_t end_excl;

    always_comb begin
        end_excl = sum_t'(start_addr) + sum_t'(byte_count);
        ovf      = end_excl > SPACE;
        zero     = byte_count == '0;
    end
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
    import eepw_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 5,
    parameter int RECOV_CYC = 5,
    parameter int GAP_LIMIT = 4000,
    parameter int PROG_CYC  = 500000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [EEPW_ADDR_W-1:0] start_addr,
    input  logic [EEPW_CNT_W-1:0]  byte_count,
    input  logic                   poll_en,
    input  logic                   s_valid,
    input  logic [EEPW_DATA_W-1:0] s_data,
    output logic                   s_ready,
    output logic [EEPW_ADDR_W-1:0] mem_addr,
    output logic [EEPW_DATA_W-1:0] mem_dout,
    output logic                   mem_drv,
    input  logic [EEPW_DATA_W-1:0] mem_din,
    output logic                   ce_n,
    output logic                   oe_n,
    output logic                   we_n,
    output logic                   busy,
    output logic                   done,
    output logic                   err
);
    localparam int PH_W  = $clog2(SETUP_CYC + PULSE_CYC + RECOV_CYC + 2) + 1;
    localparam int GAP_W = $clog2(GAP_LIMIT + SETUP_CYC + 2) + 1;
    localparam int PRG_W = $clog2(PROG_CYC + 2) + 1;

    localparam logic [PH_W-1:0]  SET_LAST = PH_W'(SETUP_CYC - 1);
    localparam logic [PH_W-1:0]  PUL_LAST = PH_W'(PULSE_CYC - 1);
    localparam logic [PH_W-1:0]  REC_LAST = PH_W'(RECOV_CYC - 1);
    localparam logic [GAP_W-1:0] GAP_TOP  = GAP_W'(GAP_LIMIT);
    localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(GAP_LIMIT + SETUP_CYC);
    localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);

    wst_t  st, st_nxt;
    beat_t cur, last;
    cnt_t  remain;
    pgn_t  page_q;
    logic  poll_q, page_open, err_q;
    logic  ovf, zero, stall_close, match, tmo_hit;
    logic  ph_clr, gap_clr, prg_clr;
    logic [PH_W-1:0]  ph_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic [PRG_W-1:0] prg_cnt;

    eepw_span_chk u_span (
        .start_addr (start_addr),
        .byte_count (byte_count),
        .ovf        (ovf),
        .zero       (zero)
    );

    eepw_timer #(.W(PH_W))  u_ph  (.clk(clk), .rst(rst), .clr(ph_clr),  .cnt(ph_cnt));
    eepw_timer #(.W(GAP_W)) u_gap (.clk(clk), .rst(rst), .clr(gap_clr), .cnt(gap_cnt));
    eepw_timer #(.W(PRG_W)) u_prg (.clk(clk), .rst(rst), .clr(prg_clr), .cnt(prg_cnt));

    assign stall_close = page_open && (gap_cnt >= GAP_TOP);
    assign match       = mem_din == last.data;
    assign tmo_hit     = (prg_cnt >= PRG_LAST) &&
                         ((st == S_PHOLD) || (st == S_PREAD && ph_cnt == PUL_LAST && !match));

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE:  if (start) st_nxt = (ovf || zero) ? S_DONE : S_WAIT;
            S_WAIT:  if (stall_close) st_nxt = S_PROG;
                     else if (s_valid) st_nxt = S_SETUP;
            S_SETUP: if (ph_cnt == SET_LAST) st_nxt = S_PULSE;
            S_PULSE: if (ph_cnt == PUL_LAST) st_nxt = S_RECOV;
            S_RECOV: if (ph_cnt == REC_LAST)
                         st_nxt = (remain == cnt_t'(1) || page_last(cur.addr)) ? S_PROG : S_WAIT;
            S_PROG:  if (poll_q) st_nxt = S_PHOLD;
                     else if (prg_cnt == PRG_LAST) st_nxt = (remain == '0) ? S_DONE : S_WAIT;
            S_PHOLD: if (tmo_hit) st_nxt = S_DONE;
                     else if (ph_cnt == REC_LAST) st_nxt = S_PREAD;
            S_PREAD: if (ph_cnt == PUL_LAST) begin
                         if (match) st_nxt = (remain == '0) ? S_DONE : S_WAIT;
                         else if (tmo_hit) st_nxt = S_DONE;
                         else st_nxt = S_PHOLD;
                     end
            S_DONE:  st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    assign ph_clr  = st_nxt != st;
    assign gap_clr = (st == S_SETUP) && (st_nxt == S_PULSE);
    assign prg_clr = (st != S_PROG) && (st_nxt == S_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cur       <= '0;
            last      <= '0;
            remain    <= '0;
            page_q    <= '0;
            poll_q    <= 1'b0;
            page_open <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st == S_IDLE && start) begin
                cur.addr  <= start_addr;
                remain    <= byte_count;
                poll_q    <= poll_en;
                page_open <= 1'b0;
                err_q     <= ovf;
            end
            if (st == S_WAIT && st_nxt == S_SETUP)
                cur.data <= s_data;
            if (gap_clr && !page_open) begin
                page_open <= 1'b1;
                page_q    <= page_of(cur.addr);
            end
            if (st == S_RECOV && st_nxt != S_RECOV) begin
                last     <= cur;
                cur.addr <= cur.addr + addr_t'(1);
                remain   <= remain - cnt_t'(1);
            end
            if (prg_clr)
                page_open <= 1'b0;
            if (tmo_hit)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        s_ready  = (st == S_WAIT) && !stall_close;
        mem_drv  = (st == S_SETUP) || (st == S_PULSE) || (st == S_RECOV);
        we_n     = st != S_PULSE;
        oe_n     = st != S_PREAD;
        ce_n     = !(mem_drv || st == S_WAIT || st == S_PHOLD || st == S_PREAD);
        mem_addr = (st == S_PHOLD || st == S_PREAD) ? last.addr : cur.addr;
        mem_dout = cur.data;
        busy     = st != S_IDLE;
        done     = st == S_DONE;
        err      = err_q;
    end

    AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> ($stable(mem_addr) && $stable(mem_dout))); // R2

    AST_BUS_SAFE: assert property (@(posedge clk) disable iff (rst)
        mem_drv |-> oe_n); // R3

    AST_PAGE_LOCK: assert property (@(posedge clk) disable iff (rst)
        ($fell(we_n) && $past(page_open)) |-> (page_of(mem_addr) == page_q)); // R5

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        ($fell(we_n) && $past(page_open)) |-> ($past(gap_cnt) < GAP_MAX)); // R6

    AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && start && ovf) |=> (done && err && we_n)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

endmodule

// File: tb/sim_eep_page_writer.sv
module sim_eep_page_writer;
    localparam int CLK_PER = 10;
    localparam int SU = 2;
    localparam int PW = 3;
    localparam int RC = 2;
    localparam int GL = 40;
    localparam int PC = 300;
    localparam int BUSY_M = 100;
    localparam int BLC_M = GL + SU;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [16:0] start_addr = '0;
    logic [17:0] byte_count = '0;
    logic        poll_en = 1'b0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dout;
    logic        mem_drv;
    logic [7:0]  mem_din = '0;
    logic        ce_n, oe_n, we_n, busy, done, err;

    eep_page_writer #(
        .SETUP_CYC(SU), .PULSE_CYC(PW), .RECOV_CYC(RC),
        .GAP_LIMIT(GL), .PROG_CYC(PC)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .poll_en(poll_en), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_drv(mem_drv), .mem_din(mem_din),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PER/2) clk = ~clk;

    int total = 0;
    int fails = 0;

    // device model state
    logic [7:0] mem_m [int];
    int  cyc = 0;
    bit  stuck = 1'b0;
    bit  seen_fall = 1'b0;
    int  bursts, viol, writes, polls, w_min, w_max, max_gap, min_pgap;
    int  last_fall = 0, last_rise = 0, busy_until = 0, low_run = 0;
    logic [16:0] fall_addr = '0;
    logic [8:0]  bpage = '0;
    logic [7:0]  last_wd = '0;
    logic prev_we = 1'b1, prev_oe = 1'b1;

    // stream source
    logic [7:0] tx_q [$];
    int  sent = 0, stall_at = -1, stall_left = 0;
    logic hs_q = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    function automatic logic [7:0] pat(input int a, input int i);
        return 8'((a >> 3) + i * 37 + 8'h5A);
    endfunction

    always @(posedge clk) hs_q <= s_valid && s_ready;

    always @(negedge clk) begin
        if (hs_q) begin
            void'(tx_q.pop_front());
            sent++;
        end
        if (tx_q.size() > 0 && sent == stall_at && stall_left > 0) begin
            s_valid = 1'b0;
            stall_left--;
        end else begin
            s_valid = tx_q.size() > 0;
            s_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (mem_drv && !oe_n) viol++;
        if (!we_n && (ce_n || !oe_n || !mem_drv)) viol++;
        if (prev_we && !we_n) begin
            if (!seen_fall || cyc - last_fall > BLC_M) begin
                bursts++;
                bpage = mem_addr[16:8];
                if (seen_fall && cyc - last_rise < min_pgap) min_pgap = cyc - last_rise;
                if (cyc < busy_until) viol++;
            end else begin
                if (mem_addr[16:8] != bpage) viol++;
                if (cyc - last_fall > max_gap) max_gap = cyc - last_fall;
            end
            seen_fall = 1'b1;
            last_fall = cyc;
            fall_addr = mem_addr;
            low_run   = 0;
        end
        if (!we_n) low_run++;
        if (!prev_we && we_n) begin
            if (mem_addr != fall_addr) viol++;
            mem_m[int'(fall_addr)] = mem_dout;
            last_wd    = mem_dout;
            last_rise  = cyc;
            busy_until = cyc + BUSY_M;
            writes++;
            if (low_run < w_min) w_min = low_run;
            if (low_run > w_max) w_max = low_run;
        end
        if (prev_oe && !oe_n) polls++;
        if (stuck || cyc < busy_until)
            mem_din = {~last_wd[7], last_wd[6:0]};
        else if (mem_m.exists(int'(mem_addr)))
            mem_din = mem_m[int'(mem_addr)];
        else
            mem_din = 8'hFF;
        prev_we = we_n;
        prev_oe = oe_n;
    end

    task automatic do_xfer(input int a, input int n, input bit pl, input int sat, input int slen,
                           output bit e, output int dcyc, output int bad);
        int t;
        bursts = 0; viol = 0; writes = 0; polls = 0;
        w_min = 1000; w_max = 0; max_gap = 0; min_pgap = 1000000;
        seen_fall = 1'b0;
        mem_m.delete();
        tx_q.delete();
        sent = 0; stall_at = sat; stall_left = slen;
        for (int i = 0; i < n; i++) tx_q.push_back(pat(a, i));
        @(negedge clk);
        start = 1'b1; start_addr = 17'(a); byte_count = 18'(n); poll_en = pl;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        e = err;
        dcyc = cyc;
        chk(done == 1'b1, "R11", "done reached", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done single cycle", int'(done), 0);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (!mem_m.exists(a + i) || mem_m[a + i] != pat(a, i)) bad++;
        end
    endtask

    task automatic t_reset();
        chk(ce_n && we_n && oe_n, "R1", "strobes high", int'({ce_n, we_n, oe_n}), 7);
        chk(!mem_drv && !s_ready, "R1", "bus and ready idle", int'({mem_drv, s_ready}), 0);
        chk(!busy && !done, "R1", "busy/done low", int'({busy, done}), 0);
    endtask

    task automatic t_single();
        bit e; int d, bad;
        do_xfer(17'h00010, 4, 1'b0, -1, 0, e, d, bad);
        chk(e == 1'b0, "R10", "no error in range", int'(e), 0);
        chk(bad == 0, "R4", "single page contents", bad, 0);
        chk(writes == 4, "R4", "load count", writes, 4);
        chk(bursts == 1, "R5", "one burst", bursts, 1);
        chk(w_min == PW && w_max == PW, "R2", "strobe width", w_max, PW);
        chk(viol == 0, "R3", "bus/strobe rule violations", viol, 0);
    endtask

    task automatic t_cross();
        bit e; int d, bad;
        do_xfer(17'h000FE, 5, 1'b0, -1, 0, e, d, bad);
        chk(bad == 0, "R4", "crossing contents", bad, 0);
        chk(bursts == 2, "R5", "split at page boundary", bursts, 2);
        chk(viol == 0, "R5", "page bits steady in burst", viol, 0);
        chk(min_pgap >= PC, "R7", "fixed programming wait", min_pgap, PC);
    endtask

    task automatic t_stall();
        bit e; int d, bad;
        do_xfer(17'h00100, 6, 1'b0, 3, 100, e, d, bad);
        chk(bad == 0, "R6", "long stall contents", bad, 0);
        chk(bursts == 2, "R6", "long stall closes page", bursts, 2);
        chk(min_pgap >= PC, "R7", "wait after early close", min_pgap, PC);
        do_xfer(17'h00200, 6, 1'b0, 3, 20, e, d, bad);
        chk(bad == 0, "R6", "short stall contents", bad, 0);
        chk(bursts == 1, "R6", "short stall keeps page", bursts, 1);
        chk(max_gap <= GL + SU, "R6", "load gap bound", max_gap, GL + SU);
    endtask

    task automatic t_poll();
        bit e; int d, bad;
        do_xfer(17'h001FD, 6, 1'b1, -1, 0, e, d, bad);
        chk(e == 1'b0, "R8", "poll no error", int'(e), 0);
        chk(bad == 0, "R8", "poll contents", bad, 0);
        chk(bursts == 2, "R8", "poll two bursts", bursts, 2);
        chk(polls > 0, "R8", "status reads issued", polls, 1);
        chk(d - last_rise < PC, "R8", "early completion", d - last_rise, PC);
        chk(viol == 0, "R8", "no load while device busy", viol, 0);
    endtask

    task automatic t_tmo();
        bit e; int d, bad;
        stuck = 1'b1;
        do_xfer(17'h00400, 2, 1'b1, -1, 0, e, d, bad);
        stuck = 1'b0;
        chk(e == 1'b1, "R9", "poll timeout error", int'(e), 1);
        chk(writes == 2, "R9", "loads before timeout", writes, 2);
        chk(polls > 1, "R9", "repeated status reads", polls, 2);
    endtask

    task automatic t_range();
        bit e; int d, bad;
        do_xfer(17'h1FFFF, 2, 1'b0, -1, 0, e, d, bad);
        chk(e == 1'b1, "R10", "overflow flagged", int'(e), 1);
        chk(writes == 0, "R10", "no loads on overflow", writes, 0);
        chk(!busy, "R10", "idle after overflow", int'(busy), 0);
        do_xfer(17'h1FFFF, 1, 1'b0, -1, 0, e, d, bad);
        chk(e == 1'b0, "R10", "last byte legal", int'(e), 0);
        chk(bad == 0, "R10", "last byte written", bad, 0);
    endtask

    task automatic t_zero();
        bit e; int d, bad;
        do_xfer(17'h00020, 0, 1'b0, -1, 0, e, d, bad);
        chk(e == 1'b0, "R11", "zero count no error", int'(e), 0);
        chk(writes == 0, "R11", "zero count no loads", writes, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_cross();
        t_stall();
        t_poll();
        t_tmo();
        t_range();
        t_zero();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
    end
endmodule